// File: doc/BRIEF.md
# Max-Propagating Logical Clock Node

This block is one node of a network whose nodes keep logical clocks close to each other. A hardware tick strobe, one pulse per oscillator step, drives a hardware counter inside the node and advances a 32-bit logical clock by one on every tick. Each neighbour link brings in clock values from a neighbour. In any cycle the node takes the largest safe value from among its own advanced clock and all valid inbound values, so the logical clock follows the fastest node it hears from and never steps back.

The node also broadcasts its logical value to every neighbour at a fixed period of T ticks, where T is a power of two. A mode parameter picks one of two variants. The basic variant compares raw inbound values and sends when its own logical clock steps onto a multiple of T. The refined variant adds a known minimum link latency to every inbound value before the comparison, and times its broadcasts from the hardware counter. Because the latency offset is also forwarded, the refined variant trades a slightly larger drift term for a skew term that grows only with the delay uncertainty per hop.

Top module: `lsync_node`

## Requirements
- R1: While reset is asserted, the hardware counter and the logical clock both take the value on `hw_init`, and no send strobe is raised. Reset is synchronous and active low.
- R2: With no inbound valid, the logical clock rises by exactly one in the cycle after each cycle with `hw_tick` high, and otherwise holds.
- R3: In refined mode an inbound value plus MIN_LAT (default 4) that is strictly greater than the node's own advanced clock (clock plus one if ticking) becomes the new logical clock in the next cycle.
- R4: In basic mode an inbound value replaces the advanced clock only when the raw value is strictly greater, and no offset is added.
- R5: An inbound value that is equal to or below the advanced clock, after any offset, has no effect, so the logical clock never decreases.
- R6: When several inbound ports are valid in one cycle, the next clock is the maximum of all of their adjusted values and the advanced own clock.
- R7: In refined mode a send happens in the cycle after a tick that moves the hardware counter onto a multiple of T (T = 2^PERIOD_LOG2, default 16). Such a send happens regardless of any adoption.
- R8: In basic mode a send happens in the cycle after a tick in which the clock steps by plain increment onto a multiple of T. A cycle in which an inbound value is adopted causes no send, even when the new value lies on or beyond a multiple.
- R9: A send is a single-cycle strobe that is raised on all outbound ports together. Each port carries the logical clock value of that cycle.
- R10: In a line of three refined nodes with hardware rates differing by up to a factor of two, fixed link delays and initial offsets of up to 10, the largest pairwise clock difference never exceeds 56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_tick | input | 1 | Hardware oscillator step; advances hardware counter and logical clock |
| hw_init | input | CW | Hardware counter value loaded during reset |
| rx_valid | input | NBR | Per-neighbour inbound value valid |
| rx_value | input | NBR*CW | Per-neighbour inbound clock values, port i in bits [i*CW +: CW] |
| lclk | output | CW | Current logical clock |
| tx_valid | output | NBR | Per-neighbour send strobe |
| tx_value | output | NBR*CW | Per-neighbour sent value, port i in bits [i*CW +: CW] |

## Verification
The hardest case to reach from the ports is a basic-mode adoption that lands on or jumps past a multiple of T. Such a cycle must not send, even though a later plain increment onto the next multiple must. A random phase places inbound values a few counts either side of the predicted clock, so adoptions, ties and rejections often fall near period boundaries. A directed step then forces a jump just past the next multiple. A separate three-node line with unequal tick rates and a nine-cycle link delay exercises the skew bound over several thousand cycles.

// File: rtl/lsync_pkg.sv
package lsync_pkg;

    typedef enum logic {
        MODE_BASIC   = 1'b0,
        MODE_REFINED = 1'b1
    } sync_mode_e;

endpackage

// File: rtl/lsync_rx_adjust.sv
module lsync_rx_adjust #(
    parameter int NBR    = 3,
    parameter int CW     = 32,
    parameter int OFFSET = 0
) (
    input  logic [NBR*CW-1:0] rx_value,
    output logic [NBR*CW-1:0] cand_value
);
    localparam logic [CW-1:0] OFF_V = CW'(OFFSET);

    for (genvar i = 0; i < NBR; i++) begin : g_port
        assign cand_value[i*CW +: CW] = rx_value[i*CW +: CW] + OFF_V;
    end

endmodule

// File: rtl/lsync_max_sel.sv
module lsync_max_sel #(
    parameter int NBR = 3,
    parameter int CW  = 32
) (
    input  logic [CW-1:0]     own_value,
    input  logic [NBR-1:0]    cand_valid,
    input  logic [NBR*CW-1:0] cand_value,
    output logic [CW-1:0]     best_value,
    output logic              adopt
);
    always_comb begin
        best_value = own_value;
        adopt      = 1'b0;
        for (int i = 0; i < NBR; i++) begin
            if (cand_valid[i] && (cand_value[i*CW +: CW] > best_value)) begin
                best_value = cand_value[i*CW +: CW];
                adopt      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lsync_period_det.sv
module lsync_period_det #(
    parameter int PL = 4
) (
    input  logic [PL-1:0] low_bits,
    input  logic          gate,
    output logic          on_period
);
    assign on_period = gate && (low_bits == '0);

endmodule

// File: rtl/lsync_node.sv
module lsync_node
    import lsync_pkg::*;
#(
    parameter int         NBR         = 3,
    parameter int         CW          = 32,
    parameter int         PERIOD_LOG2 = 4,
    parameter int         MIN_LAT     = 4,
    parameter sync_mode_e MODE        = MODE_REFINED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_tick,
    input  logic [CW-1:0]     hw_init,
    input  logic [NBR-1:0]    rx_valid,
    input  logic [NBR*CW-1:0] rx_value,
    output logic [CW-1:0]     lclk,
    output logic [NBR-1:0]    tx_valid,
    output logic [NBR*CW-1:0] tx_value
);
    localparam int            PL     = PERIOD_LOG2;
    localparam int            OFFSET = (MODE == MODE_REFINED) ? MIN_LAT : 0;
    localparam logic [CW-1:0] ONE    = {{(CW-1){1'b0}}, 1'b1};
    localparam logic [CW-1:0] HALF   = {1'b1, {(CW-1){1'b0}}};

    typedef struct packed {
        logic [CW-1:0] hw;
        logic [CW-1:0] lc;
        logic          tx_v;
        logic [CW-1:0] tx_val;
    } node_st_t;

    node_st_t st_d, st_q;

    logic [CW-1:0]     hw_plus_d;
    logic [CW-1:0]     lc_plus_d;
    logic [CW-1:0]     lc_adv_d;
    logic [NBR*CW-1:0] cand_d;
    logic [CW-1:0]     best_d;
    logic              adopt_d;
    logic [PL-1:0]     per_bits_d;
    logic              per_gate_d;
    logic              send_d;

    assign hw_plus_d = st_q.hw + ONE;
    assign lc_plus_d = st_q.lc + ONE;
    assign lc_adv_d  = hw_tick ? lc_plus_d : st_q.lc;

    lsync_rx_adjust #(.NBR(NBR), .CW(CW), .OFFSET(OFFSET)) u_adjust (
        .rx_value   (rx_value),
        .cand_value (cand_d)
    );

    lsync_max_sel #(.NBR(NBR), .CW(CW)) u_max (
        .own_value  (lc_adv_d),
        .cand_valid (rx_valid),
        .cand_value (cand_d),
        .best_value (best_d),
        .adopt      (adopt_d)
    );

    if (MODE == MODE_REFINED) begin : g_hw_timed
        assign per_bits_d = hw_plus_d[PL-1:0];
        assign per_gate_d = hw_tick;
    end else begin : g_lc_timed
        assign per_bits_d = lc_plus_d[PL-1:0];
        assign per_gate_d = hw_tick & ~adopt_d;
    end

    lsync_period_det #(.PL(PL)) u_period (
        .low_bits  (per_bits_d),
        .gate      (per_gate_d),
        .on_period (send_d)
    );

    always_comb begin
        st_d        = st_q;
        st_d.hw     = hw_tick ? hw_plus_d : st_q.hw;
        st_d.lc     = best_d;
        st_d.tx_v   = send_d;
        st_d.tx_val = best_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{hw: hw_init, lc: hw_init, tx_v: 1'b0, tx_val: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lclk = st_q.lc;

    for (genvar i = 0; i < NBR; i++) begin : g_tx
        assign tx_valid[i]          = st_q.tx_v;
        assign tx_value[i*CW +: CW] = st_q.tx_val;
    end

    AST_NO_BACKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((lclk - $past(lclk)) < HALF)); // R5

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_tick && (rx_valid == '0)) |=> (lclk == $past(lclk) + ONE)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_tick && (rx_valid == '0)) |=> $stable(lclk)); // R2

    AST_TX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid[0] |=> !tx_valid[0]); // R9

    AST_TX_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_valid == '0) || (&tx_valid))); // R9

    if (MODE == MODE_REFINED) begin : g_ast_ref
        AST_REF_GRID: assert property (@(posedge clk) disable iff (!rst_n)
            tx_valid[0] |-> (st_q.hw[PL-1:0] == '0)); // R7
    end else begin : g_ast_basic
        AST_BASIC_GRID: assert property (@(posedge clk) disable iff (!rst_n)
            tx_valid[0] |-> (lclk[PL-1:0] == '0)); // R8
    end

endmodule

// File: tb/lsync_node_bench.sv
module lsync_node_bench;
    import lsync_pkg::*;

    localparam int CW   = 32;
    localparam int PLG  = 4;
    localparam int TPER = 16;
    localparam int ML   = 4;
    localparam int LNK  = 9;
    localparam int SKEW_BOUND = 56;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit unit_done = 1'b0;
    bit line_done = 1'b0;

    // ---------------- unit DUTs ----------------
    logic          tick_u = 1'b0;
    logic [31:0]   init_u = 32'd37;
    logic [2:0]    rxv_u = '0;
    logic [95:0]   rxd_u = '0;
    logic [31:0]   lc_r, lc_b;
    logic [2:0]    txv_r, txv_b;
    logic [95:0]   txd_r, txd_b;

    lsync_node #(.NBR(3), .CW(CW), .PERIOD_LOG2(PLG), .MIN_LAT(ML), .MODE(MODE_REFINED)) u_lsync_node (
        .clk(clk), .rst_n(rst_n), .hw_tick(tick_u), .hw_init(init_u),
        .rx_valid(rxv_u), .rx_value(rxd_u),
        .lclk(lc_r), .tx_valid(txv_r), .tx_value(txd_r));

    lsync_node #(.NBR(3), .CW(CW), .PERIOD_LOG2(PLG), .MIN_LAT(ML), .MODE(MODE_BASIC)) u_lsync_node_basic (
        .clk(clk), .rst_n(rst_n), .hw_tick(tick_u), .hw_init(init_u),
        .rx_valid(rxv_u), .rx_value(rxd_u),
        .lclk(lc_b), .tx_valid(txv_b), .tx_value(txd_b));

    // reference state
    logic [31:0] m_h, m_lr, m_lb;
    logic        m_tvr, m_tvb;
    string       tag_r, tag_b;
    logic [31:0] lf = 32'h1234_5678;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic ref_next(input bit refined, input logic [31:0] l, input logic [31:0] h,
                            input logic t, input logic [2:0] v, input logic [95:0] d,
                            output logic [31:0] nl, output logic snd, output string tag);
        logic [31:0] inc, c, best;
        bit adopt;
        int nv;
        inc = l + (t ? 32'd1 : 32'd0);
        best = inc;
        adopt = 1'b0;
        nv = 0;
        for (int i = 0; i < 3; i++) begin
            if (v[i]) begin
                nv++;
                c = d[i*32 +: 32] + (refined ? 32'(ML) : 32'd0);
                if (c > best) begin
                    best = c;
                    adopt = 1'b1;
                end
            end
        end
        if (refined) snd = t && (((h + 32'd1) % TPER) == 0);
        else         snd = t && !adopt && (((l + 32'd1) % TPER) == 0);
        nl = best;
        if (nv > 1)      tag = "R6";
        else if (adopt)  tag = refined ? "R3" : "R4";
        else if (nv == 1) tag = "R5";
        else             tag = "R2";
    endtask

    task automatic drive(input logic t, input logic [2:0] v, input logic [95:0] d);
        logic [31:0] nr, nb;
        logic sr, sb;
        string tr, tb;
        tick_u = t;
        rxv_u = v;
        rxd_u = d;
        ref_next(1'b1, m_lr, m_h, t, v, d, nr, sr, tr);
        ref_next(1'b0, m_lb, m_h, t, v, d, nb, sb, tb);
        m_lr = nr; m_lb = nb; m_tvr = sr; m_tvb = sb;
        tag_r = tr; tag_b = tb;
        if (t) m_h = m_h + 32'd1;
    endtask

    task automatic compare();
        chk(lc_r == m_lr, {tag_r, " refined clock"}, lc_r, m_lr);
        chk(lc_b == m_lb, {tag_b, " basic clock"}, lc_b, m_lb);
        chk(txv_r == {3{m_tvr}}, "R7 refined send strobe", 32'(txv_r), 32'({3{m_tvr}}));
        chk(txv_b == {3{m_tvb}}, "R8 basic send strobe", 32'(txv_b), 32'({3{m_tvb}}));
        if (m_tvr) for (int i = 0; i < 3; i++)
            chk(txd_r[i*32 +: 32] == m_lr, "R9 refined sent value", txd_r[i*32 +: 32], m_lr);
        if (m_tvb) for (int i = 0; i < 3; i++)
            chk(txd_b[i*32 +: 32] == m_lb, "R9 basic sent value", txd_b[i*32 +: 32], m_lb);
    endtask

    function automatic logic [31:0] near(input logic [31:0] base, input logic [3:0] r);
        return base + 32'($signed({1'b0, r}) - 8);
    endfunction

    initial begin : unit_seq
        logic [31:0] k, base;
        logic [95:0] d;
        m_h = 32'd37; m_lr = 32'd37; m_lb = 32'd37;
        m_tvr = 1'b0; m_tvb = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset load
        chk(lc_r == 32'd37, "R1 refined reset clock", lc_r, 32'd37);
        chk(lc_b == 32'd37, "R1 basic reset clock", lc_b, 32'd37);
        chk(txv_r == 3'b000 && txv_b == 3'b000, "R1 no send in reset", 32'({txv_r, txv_b}), 32'd0);
        rst_n = 1'b1;
        drive(1'b0, 3'b000, '0);
        // plain ticking: R2 and periodic sends R7/R8
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            compare();
            drive((n % 3) != 2, 3'b000, '0);
        end
        // random mix near boundaries: R3 R4 R5 R6
        for (int n = 0; n < 1500; n++) begin
            @(negedge clk);
            compare();
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            base = lf[31] ? m_lr : m_lb;
            d = {near(base, lf[19:16]), near(base, lf[15:12]), near(base, lf[11:8])};
            drive(lf[0] | lf[1], {lf[2] & lf[3], lf[4] & lf[5], lf[6] & lf[7]}, d);
        end
        // directed R8: basic jump past the next multiple, no send
        @(negedge clk);
        compare();
        k = ((m_lb / TPER) + 32'd1) * TPER;
        drive(1'b1, 3'b001, {64'd0, k + 32'd3});
        @(negedge clk);
        chk(txv_b == 3'b000, "R8 jump past multiple sends nothing", 32'(txv_b), 32'd0);
        chk(lc_b == k + 32'd3, "R4 jump adopted", lc_b, k + 32'd3);
        compare();
        // directed R5: tie with advanced clock is ignored
        drive(1'b1, 3'b010, {32'd0, m_lb + 32'd1, 32'd0});
        @(negedge clk);
        chk(lc_b == k + 32'd4, "R5 tie ignored", lc_b, k + 32'd4);
        compare();
        // directed R6: three ports, largest wins
        drive(1'b0, 3'b111, {m_lb + 32'd7, m_lb + 32'd20, m_lb + 32'd2});
        @(negedge clk);
        chk(lc_b == k + 32'd24, "R6 max of three", lc_b, k + 32'd24);
        compare();
        drive(1'b0, 3'b000, '0);
        @(negedge clk);
        compare();
        unit_done = 1'b1;
    end

    // ---------------- line of three refined nodes (R10) ----------------
    logic        lt   [3];
    logic [1:0]  lrxv [3];
    logic [63:0] lrxd [3];
    logic [31:0] llc  [3];
    logic [1:0]  ltxv [3];
    logic [63:0] ltxd [3];

    for (genvar g = 0; g < 3; g++) begin : g_line
        lsync_node #(.NBR(2), .CW(CW), .PERIOD_LOG2(PLG), .MIN_LAT(ML), .MODE(MODE_REFINED)) u_line_node (
            .clk(clk), .rst_n(rst_n), .hw_tick(lt[g]), .hw_init(32'(5 * g)),
            .rx_valid(lrxv[g]), .rx_value(lrxd[g]),
            .lclk(llc[g]), .tx_valid(ltxv[g]), .tx_value(ltxd[g]));
    end

    initial begin : line_seq
        logic        dv [3][LNK];
        logic [31:0] dd [3][LNK];
        logic [31:0] mx, mn;
        for (int j = 0; j < 3; j++) begin
            lt[j] = 1'b0; lrxv[j] = '0; lrxd[j] = '0;
            for (int k = 0; k < LNK; k++) begin dv[j][k] = 1'b0; dd[j][k] = '0; end
        end
        wait (rst_n);
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            mx = llc[0]; mn = llc[0];
            for (int j = 1; j < 3; j++) begin
                if (llc[j] > mx) mx = llc[j];
                if (llc[j] < mn) mn = llc[j];
            end
            chk((mx - mn) <= 32'(SKEW_BOUND), "R10 line skew", mx - mn, 32'(SKEW_BOUND));
            for (int j = 0; j < 3; j++) begin
                for (int k = LNK - 1; k > 0; k--) begin
                    dv[j][k] = dv[j][k-1];
                    dd[j][k] = dd[j][k-1];
                end
                dv[j][0] = ltxv[j][0];
                dd[j][0] = ltxd[j][31:0];
            end
            lrxv[0] = {1'b0, dv[1][LNK-1]};          lrxd[0] = {32'd0, dd[1][LNK-1]};
            lrxv[1] = {dv[2][LNK-1], dv[0][LNK-1]};  lrxd[1] = {dd[2][LNK-1], dd[0][LNK-1]};
            lrxv[2] = {1'b0, dv[1][LNK-1]};          lrxd[2] = {32'd0, dd[1][LNK-1]};
            lt[0] = 1'b1;
            lt[1] = (cyc % 4) != 3;
            lt[2] = (cyc % 2) == 0;
        end
        line_done = 1'b1;
    end

    initial begin : finish_seq
        wait (unit_done && line_done);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule